// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counters of a CAN node and derives the node's fault confinement state from them. The protocol engine feeds it one-cycle strobes for each counting event. The events are detected receive errors, a dominant bit after the node's own receive error flag, transmit errors, bit errors while driving an active error or overload flag, runs of excessive dominant bits after a flag, and successful transmissions and receptions. A role input says whether the node is currently transmitting. That input decides which counter takes the role-dependent events.

Both counters saturate instead of wrapping. The node becomes error-passive once either counter passes 127 and returns to error-active when both are back at 127 or below. It goes bus-off when a transmit increment would carry the transmit counter past its maximum. In bus-off the transmit counter stays at its maximum and every counting event is ignored until the recovery input clears both counters. When several strobes arrive in one cycle, only the highest-priority event is applied.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counters read 0, the state output reads 2'b00 (error-active), and the warning, passive and bus-off flags are low.
- R2: A `rx_err` strobe adds 1 to the receive counter.
- R3: A `rx_flag_dom` strobe adds 8 to the receive counter.
- R4: A `tx_err` strobe adds 8 to the transmit counter, unless `tx_exempt` is high in the same cycle, in which case neither counter changes.
- R5: A `flag_bit_err` or `excess_dom` strobe adds 8 to the transmit counter when `is_tx` is 1, and to the receive counter when `is_tx` is 0.
- R6: A `tx_ok` strobe lowers the transmit counter by 1. A counter already at 0 stays at 0.
- R7: A `rx_ok` strobe lowers the receive counter by 1 when it is between 1 and 127. It leaves 0 at 0 and reloads any value above 127 to 120.
- R8: The state output reads 2'b01 (error-passive) and `passive` is high while either counter exceeds 127 and the node is not bus-off. The state returns to 2'b00 once both counters are 127 or less.
- R9: `warn` is high exactly when either counter is 96 or more.
- R10: When a transmit increment would carry the transmit counter past 255, the counter becomes 255, the state reads 2'b10 and `bus_off` goes high. While bus-off, all counting strobes leave both counters unchanged.
- R11: A `recover` strobe clears both counters to 0 and leaves bus-off, giving state 2'b00.
- R12: When several strobes arrive in one cycle, only one is applied. The order is `tx_err` (not exempt), then `flag_bit_err`, then `excess_dom`, then `rx_flag_dom`, then `rx_err`, then `tx_ok`, then `rx_ok`.
- R13: The receive counter saturates at 255 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_tx | input | 1 | Node is currently the transmitter |
| rx_err | input | 1 | Receive error detected |
| rx_flag_dom | input | 1 | Dominant bit seen after own receive error flag |
| tx_err | input | 1 | Transmit error flag sent |
| tx_exempt | input | 1 | Current transmit error is an exempt case |
| flag_bit_err | input | 1 | Bit error while driving an active error or overload flag |
| excess_dom | input | 1 | Excessive dominant bits after a flag |
| tx_ok | input | 1 | Frame transmitted successfully |
| rx_ok | input | 1 | Frame received successfully |
| recover | input | 1 | Bus-off recovery complete |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| state | output | 2 | 00 active, 01 passive, 10 bus-off |
| warn | output | 1 | Either counter at or above the warning level |
| passive | output | 1 | Either counter above the passive level |
| bus_off | output | 1 | Node is bus-off |

## Verification
Increments and decrements can collide in one cycle. A flag bit error can coincide with the plain receive error it replaces, and a receive error can arrive together with both success strobes. The bench raises such strobe groups in a single cycle and checks that only the highest-ranked event moved a counter, by the exact amount that event calls for. A second collision happens at the edge of bus-off: the bench drives success strobes while bus-off is active and checks that both counters hold until recovery.

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
  parameter int CNT_W       = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 127,
  parameter int RX_RELOAD   = 120,
  parameter int BIG_STEP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_tx,
  input  logic             rx_err,
  input  logic             rx_flag_dom,
  input  logic             tx_err,
  input  logic             tx_exempt,
  input  logic             flag_bit_err,
  input  logic             excess_dom,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             recover,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       state,
  output logic             warn,
  output logic             passive,
  output logic             bus_off
);
  localparam logic [CNT_W:0]   MAX_W  = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] MAXV   = MAX_W[CNT_W-1:0];
  localparam logic [CNT_W-1:0] WARN   = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASV   = CNT_W'(PASSIVE_LVL);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RX_RELOAD);
  localparam logic [CNT_W:0]   STEP   = (CNT_W+1)'(BIG_STEP);

  typedef enum logic [2:0] {
    OP_NONE, OP_TX_UP8, OP_RX_UP8, OP_RX_UP1, OP_TX_DN, OP_RX_DN
  } op_t;

  op_t op;
  logic tx_hit;
  logic [CNT_W:0] tec_up, rec_up, rec_up1;

  assign tx_hit  = tx_err && !tx_exempt;
  assign tec_up  = {1'b0, tec} + STEP;
  assign rec_up  = {1'b0, rec} + STEP;
  assign rec_up1 = {1'b0, rec} + 1'b1;

  always_comb begin
    op = OP_NONE;
    if (tx_hit)                          op = OP_TX_UP8;
    else if (flag_bit_err || excess_dom) op = is_tx ? OP_TX_UP8 : OP_RX_UP8;
    else if (rx_flag_dom)                op = OP_RX_UP8;
    else if (rx_err)                     op = OP_RX_UP1;
    else if (tx_ok)                      op = OP_TX_DN;
    else if (rx_ok)                      op = OP_RX_DN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec     <= '0;
      rec     <= '0;
      bus_off <= 1'b0;
    end else if (recover) begin
      tec     <= '0;
      rec     <= '0;
      bus_off <= 1'b0;
    end else if (!bus_off) begin
      unique case (op)
        OP_TX_UP8: begin
          if (tec_up > MAX_W) begin
            tec     <= MAXV;
            bus_off <= 1'b1;
          end else begin
            tec <= tec_up[CNT_W-1:0];
          end
        end
        OP_RX_UP8: rec <= (rec_up > MAX_W) ? MAXV : rec_up[CNT_W-1:0];
        OP_RX_UP1: rec <= (rec_up1 > MAX_W) ? MAXV : rec_up1[CNT_W-1:0];
        OP_TX_DN:  if (tec != '0) tec <= tec - 1'b1;
        OP_RX_DN: begin
          if (rec > PASV)      rec <= RELOAD;
          else if (rec != '0)  rec <= rec - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign passive = (tec > PASV) || (rec > PASV);
  assign warn    = (tec >= WARN) || (rec >= WARN);
  assign state   = bus_off ? 2'b10 : (passive ? 2'b01 : 2'b00);

  logic lone_rx_ok, lone_tx_ok;
  assign lone_rx_ok = rx_ok && !tx_ok && !rx_err && !rx_flag_dom && !tx_hit &&
                      !flag_bit_err && !excess_dom && !recover && !bus_off;
  assign lone_tx_ok = tx_ok && !rx_err && !rx_flag_dom && !tx_hit &&
                      !flag_bit_err && !excess_dom && !recover && !bus_off;

  p_busoff_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> tec == MAXV);
  p_busoff_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off && !recover |=> $stable(tec) && $stable(rec));
  p_recover_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> tec == '0 && rec == '0 && !bus_off);
  p_rx_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lone_rx_ok && rec > PASV |=> rec == RELOAD);
  p_tx_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lone_tx_ok && tec == '0 |=> tec == '0);
  p_state_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);
endmodule

// File: tb/tb_can_fault_counters.sv
module tb_can_fault_counters;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_tx = 0, rx_err = 0, rx_flag_dom = 0, tx_err = 0, tx_exempt = 0;
  logic flag_bit_err = 0, excess_dom = 0, tx_ok = 0, rx_ok = 0, recover = 0;
  logic [7:0] tec, rec;
  logic [1:0] state;
  logic warn, passive, bus_off;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_counters dut (
    .clk(clk), .rst_n(rst_n), .is_tx(is_tx), .rx_err(rx_err),
    .rx_flag_dom(rx_flag_dom), .tx_err(tx_err), .tx_exempt(tx_exempt),
    .flag_bit_err(flag_bit_err), .excess_dom(excess_dom), .tx_ok(tx_ok),
    .rx_ok(rx_ok), .recover(recover), .tec(tec), .rec(rec), .state(state),
    .warn(warn), .passive(passive), .bus_off(bus_off)
  );

  // event field: [8]is_tx [7]tx_err [6]tx_exempt [5]flag_bit_err [4]excess_dom
  //              [3]rx_flag_dom [2]rx_err [1]tx_ok [0]rx_ok
  localparam int NV = 11;
  localparam logic [24:0] VEC [0:NV-1] = '{
    {9'b000000100, 8'd0,  8'd1 },  // R2
    {9'b000001000, 8'd0,  8'd9 },  // R3
    {9'b010000000, 8'd8,  8'd9 },  // R4
    {9'b011000000, 8'd8,  8'd9 },  // R4 exempt
    {9'b100100000, 8'd16, 8'd9 },  // R5 tx role
    {9'b000010000, 8'd16, 8'd17},  // R5 rx role
    {9'b000100100, 8'd16, 8'd25},  // R12 flag bit error over rx_err
    {9'b000000010, 8'd15, 8'd25},  // R6
    {9'b000000001, 8'd15, 8'd24},  // R7
    {9'b000000111, 8'd15, 8'd25},  // R12 rx_err over successes
    {9'b100010000, 8'd23, 8'd25}   // R5 excess dominant, tx role
  };
  localparam int VREQ [0:NV-1] = '{2, 3, 4, 4, 5, 5, 12, 6, 7, 12, 5};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [8:0] ev);
    @(negedge clk);
    {is_tx, tx_err, tx_exempt, flag_bit_err, excess_dom,
     rx_flag_dom, rx_err, tx_ok, rx_ok} = ev;
    @(negedge clk);
    {tx_err, tx_exempt, flag_bit_err, excess_dom,
     rx_flag_dom, rx_err, tx_ok, rx_ok} = '0;
  endtask

  function automatic int exp_state(input int t, input int r, input bit boff);
    if (boff) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  task automatic check_all(input string req, input int t, input int r, input bit boff);
    check({req, " tec"}, int'(tec), t);
    check({req, " rec"}, int'(rec), r);
    check({req, " state"}, int'(state), exp_state(t, r, boff));
    check({req, " warn R9"}, int'(warn), int'(t >= 96 || r >= 96));
    check({req, " bus_off"}, int'(bus_off), int'(boff));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset", 0, 0, 0);
    check("R1 passive", int'(passive), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][24:16]);
      check_all($sformatf("R%0d vector %0d", VREQ[i], i),
                int'(VEC[i][15:8]), int'(VEC[i][7:0]), 0);
    end

    // R6 floor at zero
    for (int i = 0; i < 25; i++) pulse(9'b000000010);
    check_all("R6 floor", 0, 25, 0);

    // R9 warning threshold on rec
    for (int i = 0; i < 70; i++) pulse(9'b000000100);
    check_all("R9 at 95", 0, 95, 0);
    pulse(9'b000000100);
    check_all("R9 at 96", 0, 96, 0);

    // R8 passive above 127
    for (int i = 0; i < 31; i++) pulse(9'b000000100);
    check_all("R8 at 127", 0, 127, 0);
    pulse(9'b000000100);
    check_all("R8 at 128", 0, 128, 0);
    check("R8 passive flag", int'(passive), 1);

    // R7 reload to 120, back to active
    pulse(9'b000000001);
    check_all("R7 reload", 0, 120, 0);

    // R13 saturation
    for (int i = 0; i < 20; i++) pulse(9'b000001000);
    check_all("R13 saturate", 0, 255, 0);
    pulse(9'b000000100);
    check_all("R13 +1 saturate", 0, 255, 0);
    pulse(9'b000000001);
    check_all("R7 reload from 255", 0, 120, 0);
    for (int i = 0; i < 120; i++) pulse(9'b000000001);
    check_all("R7 down to 0", 0, 0, 0);
    pulse(9'b000000001);
    check_all("R7 hold 0", 0, 0, 0);

    // R10 bus-off
    for (int i = 0; i < 31; i++) pulse(9'b010000000);
    check_all("R10 at 248", 248, 0, 0);
    pulse(9'b010000000);
    check_all("R10 enter", 255, 0, 1);
    pulse(9'b000000010);
    check_all("R10 ignore tx_ok", 255, 0, 1);
    pulse(9'b000000100);
    check_all("R10 ignore rx_err", 255, 0, 1);

    // R11 recovery
    @(negedge clk); recover = 1'b1;
    @(negedge clk); recover = 1'b0;
    check_all("R11 recover", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule